// File: doc/BRIEF.md
# Single-Cycle Signed Booth Multiplier

This block multiplies two signed two's-complement operands and returns the full double-width product. The operands are captured in an input register stage together with a qualifying strobe. In the following cycle the whole product is formed and stored in an output register, which also carries a strobe.

Inside the block, the multiplier operand is split into bit pairs. Each pair, read together with the top bit of the pair below it, becomes one signed digit in {-2, -1, 0, +1, +2}. Each digit selects a scaled copy of the multiplicand, which is then shifted into position. A negative selection is inverted, and the missing +1 is added as a separate row. All rows are summed in a tree of 3:2 carry-save compressors, and a single carry-propagate adder finishes the sum. No absolute value is taken and the result is never negated.

The default width is 16 bits per operand. The width must be even.

Top module: `booth_mult`

## Requirements
- R1: When `out_valid` is high, `product_o` equals the signed two's-complement product of the `mcand_i` and `mplier_i` values that were sampled with `in_valid` high two rising edges earlier. The product uses all 2·W bits.
- R2: `out_valid` rises on the second rising clock edge after `in_valid` is sampled high. It stays high for exactly one cycle for each accepted input.
- R3: While no new result arrives, `product_o` keeps its last value and `out_valid` stays low.
- R4: While `rst` is high at a rising edge, `out_valid` becomes 0 and `product_o` becomes 0 on that edge.
- R5: The most negative value times itself (-32768 × -32768 at W=16) gives +2^30, which is 0x40000000.
- R6: The most negative value times the most positive value (-32768 × 32767) gives 0xC0008000.
- R7: A zero operand on either side gives a zero product, whatever the other operand is.
- R8: Each recoding case gives the correct sum: pairs 00, 01, 10 and 11, each with an incoming bit of 0 and of 1. This is tested with alternating patterns (0x5555, 0xAAAA), runs of ones, and -1 × -1 = 1.
- R9: Inputs accepted on consecutive cycles give one result per cycle, in the same order as the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on this cycle are to be multiplied |
| mcand_i | input | W | Signed multiplicand |
| mplier_i | input | W | Signed multiplier (the recoded operand) |
| out_valid | output | 1 | `product_o` holds a new result for one cycle |
| product_o | output | 2·W | Signed product, held between results |

## Verification
The bench targets the sign extremes:
- Squaring the most negative value gives a product that needs the top bit pair to recode as -2. A design that sign-extended a row wrongly, or that lost the injected +1, would return a negative or an off-by-one value.
- For most-negative × most-positive, a dropped carry out of the compressor tree shows up in the upper half.

The alternating and all-ones patterns force every digit value from the recoding table. A design that swapped the incoming-bit position, or negated the wrong rows, would give wrong products on them.

Back-to-back inputs and idle gaps expose a strobe placed in the wrong cycle, and a product register that updates without new data.

// File: rtl/booth_mult_pkg.sv
package booth_mult_pkg;

  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } booth_digit_t;

  // number of 3:2 levels needed to bring n rows down to two
  function automatic int csa_levels(input int n);
    int rows;
    int lv;
    rows = n;
    lv   = 0;
    while (rows > 2) begin
      rows = (rows / 3) * 2 + (rows % 3);
      lv   = lv + 1;
    end
    return lv;
  endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_mult_pkg::*;
#(
  parameter int W = 16,
  localparam int ND = W / 2
) (
  input  logic [W-1:0]             mplier,
  output booth_digit_t [ND-1:0]    digits
);

  for (genvar i = 0; i < ND; i++) begin : g_dig
    logic hi, mid, lo;
    assign hi  = mplier[2*i+1];
    assign mid = mplier[2*i];
    if (i == 0) begin : g_first
      assign lo = 1'b0;
    end else begin : g_rest
      assign lo = mplier[2*i-1];
    end
    assign digits[i].one = mid ^ lo;
    assign digits[i].two = (hi & ~mid & ~lo) | (~hi & mid & lo);
    assign digits[i].neg = hi & ~(mid & lo);
  end

endmodule

// File: rtl/booth_pp_row.sv
module booth_pp_row
  import booth_mult_pkg::*;
#(
  parameter int W   = 16,
  parameter int IDX = 0,
  localparam int W2 = 2 * W
) (
  input  logic [W-1:0]  mcand,
  input  booth_digit_t  digit,
  output logic [W2-1:0] row
);

  logic [W2-1:0] ext;
  logic [W2-1:0] sel;
  logic [W2-1:0] inv;

  assign ext = {{W{mcand[W-1]}}, mcand};

  always_comb begin
    if (digit.one)      sel = ext;
    else if (digit.two) sel = ext << 1;
    else                sel = '0;
    inv = digit.neg ? ~sel : sel;
    row = inv << (2 * IDX);
  end

endmodule

// File: rtl/csa_tree.sv
module csa_tree
  import booth_mult_pkg::*;
#(
  parameter int W    = 32,
  parameter int N_IN = 9,
  localparam int LEVELS = csa_levels(N_IN)
) (
  input  logic [W-1:0] rows_i [N_IN],
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);

  logic [W-1:0] cur [N_IN];
  logic [W-1:0] nxt [N_IN];

  always_comb begin
    int n;
    int k;
    cur = rows_i;
    nxt = '{default: '0};
    n   = N_IN;
    for (int lv = 0; lv < LEVELS; lv++) begin
      nxt = '{default: '0};
      k   = 0;
      for (int g = 0; g < N_IN; g += 3) begin
        if (g + 2 < n) begin
          nxt[k]   = cur[g] ^ cur[g+1] ^ cur[g+2];
          nxt[k+1] = ((cur[g] & cur[g+1]) | (cur[g] & cur[g+2]) |
                      (cur[g+1] & cur[g+2])) << 1;
          k = k + 2;
        end else if (g < n) begin
          nxt[k] = cur[g];
          k = k + 1;
          if (g + 1 < n) begin
            nxt[k] = cur[g+1];
            k = k + 1;
          end
        end
      end
      cur = nxt;
      n   = k;
    end
    sum_o   = cur[0];
    carry_o = cur[1];
  end

endmodule

// File: rtl/booth_mult.sv
module booth_mult
  import booth_mult_pkg::*;
#(
  parameter int W = 16,
  localparam int W2 = 2 * W,
  localparam int ND = W / 2,
  localparam int NR = ND + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  mcand_i,
  input  logic [W-1:0]  mplier_i,
  output logic          out_valid,
  output logic [W2-1:0] product_o
);

  logic [W-1:0]         mcand_q;
  logic [W-1:0]         mplier_q;
  logic                 valid_q;
  booth_digit_t [ND-1:0] digits;
  logic [W2-1:0]        rows [NR];
  logic [W2-1:0]        fix_row;
  logic [W2-1:0]        tree_sum;
  logic [W2-1:0]        tree_carry;
  logic [W2-1:0]        full_sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        mcand_q  <= mcand_i;
        mplier_q <= mplier_i;
      end
    end
  end

  booth_recoder #(.W(W)) u_rec (
    .mplier (mplier_q),
    .digits (digits)
  );

  for (genvar i = 0; i < ND; i++) begin : g_pp
    booth_pp_row #(.W(W), .IDX(i)) u_row (
      .mcand (mcand_q),
      .digit (digits[i]),
      .row   (rows[i])
    );
  end

  // +1 for each inverted row, placed at that row's weight
  always_comb begin
    fix_row = '0;
    for (int i = 0; i < ND; i++) begin
      fix_row[2*i] = digits[i].neg;
    end
  end
  assign rows[ND] = fix_row;

  csa_tree #(.W(W2), .N_IN(NR)) u_tree (
    .rows_i  (rows),
    .sum_o   (tree_sum),
    .carry_o (tree_carry)
  );

  assign full_sum = tree_sum + tree_carry;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      product_o <= '0;
    end else begin
      out_valid <= valid_q;
      if (valid_q) product_o <= full_sum;
    end
  end

endmodule

// File: rtl/booth_mult_chk.sv
module booth_mult_chk #(
  parameter int W = 16,
  localparam int W2 = 2 * W
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [W-1:0]  mcand_i,
  input logic [W-1:0]  mplier_i,
  input logic          out_valid,
  input logic [W2-1:0] product_o
);

  logic signed [W2-1:0] ref_prod;
  assign ref_prod = $signed(mcand_i) * $signed(mplier_i);

  AST_RESULT_VALUE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> product_o == $past(ref_prod, 2)); // R1

  AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid); // R2

  AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$stable(product_o) |-> out_valid); // R3

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!out_valid && product_o == '0)); // R4

endmodule

bind booth_mult booth_mult_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .mcand_i   (mcand_i),
  .mplier_i  (mplier_i),
  .out_valid (out_valid),
  .product_o (product_o)
);

// File: tb/test_booth_mult.sv
module test_booth_mult;

  localparam int W  = 16;
  localparam int W2 = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [W-1:0]  mcand_i = '0;
  logic [W-1:0]  mplier_i = '0;
  logic          out_valid;
  logic [W2-1:0] product_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  booth_mult #(.W(W)) i_booth_mult (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .out_valid (out_valid),
    .product_o (product_o)
  );

  function automatic logic [W2-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [W2-1:0] r;
    r = $signed(a) * $signed(b);
    return r;
  endfunction

  task automatic check(input string req, input logic [W2-1:0] act, input logic [W2-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // apply one operand pair, check the strobe timing, value and hold
  task automatic mul_once(input string req, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W2-1:0] exp;
    exp = ref_mul(a, b);
    @(negedge clk);
    mcand_i  = a;
    mplier_i = b;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    mcand_i  = ~a;
    mplier_i = ~b;
    check({req, "/R2 strobe not early"}, {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    check({req, "/R2 strobe"}, {31'd0, out_valid}, 32'd1);
    check(req, product_o, exp);
    @(negedge clk);
    check("R3 strobe drops", {31'd0, out_valid}, 32'd0);
    check("R3 product held", product_o, exp);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 out_valid", {31'd0, out_valid}, 32'd0);
    check("R4 product", product_o, 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_extremes();
    mul_once("R5", 16'h8000, 16'h8000);
    check("R5 literal", product_o, 32'h4000_0000);
    mul_once("R6", 16'h8000, 16'h7FFF);
    check("R6 literal", product_o, 32'hC000_8000);
    mul_once("R6 swapped", 16'h7FFF, 16'h8000);
    check("R6 swapped literal", product_o, 32'hC000_8000);
  endtask

  task automatic t_zero();
    mul_once("R7 zero multiplier", 16'h8000, 16'h0000);
    mul_once("R7 zero multiplicand", 16'h0000, 16'hFFFF);
    mul_once("R7 zero multiplicand b", 16'h0000, 16'h8000);
  endtask

  task automatic t_patterns();
    mul_once("R8 -1x-1", 16'hFFFF, 16'hFFFF);
    check("R8 -1x-1 literal", product_o, 32'd1);
    mul_once("R8 5555x5555", 16'h5555, 16'h5555);
    mul_once("R8 AAAAxAAAA", 16'hAAAA, 16'hAAAA);
    mul_once("R8 5555xAAAA", 16'h5555, 16'hAAAA);
    mul_once("R8 7FFFx3333", 16'h7FFF, 16'h3333);
    mul_once("R8 1234xCCCC", 16'h1234, 16'hCCCC);
    mul_once("R8 run of ones", 16'h0123, 16'h0FF0);
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++) begin
      mul_once("R1 random", 16'($urandom), 16'($urandom));
    end
  endtask

  task automatic t_stream();
    logic [W-1:0]  av [6];
    logic [W-1:0]  bv [6];
    for (int i = 0; i < 6; i++) begin
      av[i] = 16'($urandom);
      bv[i] = 16'($urandom);
    end
    av[2] = 16'h8000; bv[2] = 16'h8000;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      if (j >= 2) begin
        check("R9 stream strobe", {31'd0, out_valid}, 32'd1);
        check("R9 stream value", product_o, ref_mul(av[j-2], bv[j-2]));
      end
      if (j < 6) begin
        mcand_i  = av[j];
        mplier_i = bv[j];
        in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    check("R9 stream ends", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_extremes();
    t_zero();
    t_patterns();
    t_random();
    t_stream();
    t_reset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule